// File: doc/BRIEF.md
# Fluorescent Display Multiplex and Key Scan Sequencer

This block sequences a multiplexed vacuum-fluorescent display and scans a small key matrix from the same segment lines. It steps through a configurable number of grid positions, from 8 to 16. Each position lasts a fixed number of clocks. For each position it fetches one 20-bit word from an internal display store. The segment pattern and the single active grid pass through a registered output stage. A dimming value limits how long each grid is lit inside its slot. A global enable can blank the display.

The top eight segment lines can be switched one by one into grid duty, in reverse order: the highest line carries grid 9 and line 13 carries grid 16. After the last grid of each display cycle comes a key-scan slot. In that slot the twelve lowest segment lines are raised one at a time as key sources, and four return inputs are sampled for each source. The samples are committed to a 4 x 12 key store only at the end of the display cycle. A reader can hold off that commit while it walks through the key store byte by byte.

Top module: `vfd_scan_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `seg_out`, `grid_out` and `key_rd_data` become zero, the display store words become zero and every key store entry becomes zero.
- R2: Outputs are registered one clock after the scan position. A display cycle has G grid slots, where G = 8 + `grid_sel` for `grid_sel` ≤ 8 and G = 16 above that. Each slot lasts SLOT_LEN clocks. While lit, slot k (0-based) asserts grid k+1 and no other grid. Grids 1 to 8 drive `grid_out[k]`. The grid count is re-read at the end of each slot.
- R3: Grid g, for g from 9 to 16, is carried on `seg_out[28-g]`, which is segment line 29-g (line 20 is grid 9 and line 13 is grid 16). These lines are in grid duty only when g ≤ G.
- R4: While slot k is lit, `seg_out[i]` equals bit i of display word k for i < 28-G. Lines in grid duty never carry word data.
- R5: Within a slot, outputs are lit only for the first (`dim`+1)·SLOT_LEN/16 clocks of the slot. `dim` is a 3-bit value. For the rest of the slot, `seg_out` and `grid_out` are zero.
- R6: While `disp_on` is low, every display slot drives zero on `seg_out` and `grid_out`.
- R7: After the last grid slot comes a key slot of 12·KEY_DWELL clocks. Source s (1 to 12) is driven alone on `seg_out[s-1]` for KEY_DWELL consecutive clocks, in rising order. All grids are off during the key slot. The key slot runs whatever the value of `disp_on`.
- R8: The return inputs `key_ret` are sampled on the last clock of each source's window. The key store changes only on the final clock of the key slot, when it takes all twelve new samples together.
- R9: `key_rd_data` shows, one clock after `key_rd_idx` = b, byte b of the key store. For b < 6, bits 3:0 hold source 2b+1 and bits 7:4 hold source 2b+2, with bit r of a nibble being return r+1. For b ≥ 6 it reads zero.
- R10: If `key_rd_hold` is high on the final clock of the key slot, the key store keeps its contents. The next cycle end without the hold commits that cycle's samples.
- R11: A write with `wr_en` high stores `wr_data` at `wr_addr`. The new word is used from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_on | input | 1 | Display enable |
| grid_sel | input | 4 | Grid count selector (G = 8 + value, saturating at 16) |
| dim | input | 3 | Lit-time fraction, (dim+1)/16 of a slot |
| wr_en | input | 1 | Display store write strobe |
| wr_addr | input | 4 | Display store word address (grid position) |
| wr_data | input | 20 | Display store write word |
| key_ret | input | 4 | Key return lines |
| key_rd_hold | input | 1 | Blocks the end-of-cycle key store commit |
| key_rd_idx | input | 3 | Key store byte index |
| key_rd_data | output | 8 | Registered key store byte |
| seg_out | output | 20 | Segment lines, shared with key sources and upper grids |
| grid_out | output | 8 | Dedicated grid lines 1 to 8 |

## Verification
The bench sweeps the grid count across 8, 11 and 16 and also drives a selector above 8. A design that mapped the shared lines in forward order, or left word data on a line in grid duty, would show a wrong bit on `seg_out` in the upper slots. Dimming is checked at the smallest, middle and full values, so an off-by-one on the lit window shows up at the edge clock of each slot. Key patterns change between cycles, and the hold is raised across one cycle end. A design that committed samples as they arrived, dropped the twelfth source's same-clock sample, or ignored the hold would return stale or early bytes on `key_rd_data`. Readout indices 6 and 7 must read zero.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

    localparam int SEG_N     = 20;
    localparam int DED_GRIDS = 8;
    localparam int MAX_GRIDS = 16;
    localparam int KEY_SRCS  = 12;
    localparam int KEY_RETS  = 4;
    localparam int DIM_W     = 3;
    localparam int GSEL_W    = 4;
    localparam int RD_IDX_W  = 3;
    localparam int SLOT_W    = $clog2(MAX_GRIDS);
    localparam int CNT_W     = $clog2(MAX_GRIDS + 1);
    localparam int KSRC_W    = $clog2(KEY_SRCS);
    localparam int SUB_W     = 8;
    localparam int KEY_BITS  = KEY_SRCS * KEY_RETS;
    localparam int KEY_BYTES = KEY_BITS / 8;
    localparam int SHARED    = MAX_GRIDS - DED_GRIDS;

    typedef logic [SEG_N-1:0]    seg_word_t;
    typedef logic [KEY_RETS-1:0] key_nib_t;

    typedef struct packed {
        logic              in_key;
        logic              lit;
        logic              capture;
        logic              cycle_end;
        logic [SLOT_W-1:0] slot;
        logic [KSRC_W-1:0] ksrc;
    } scan_pos_t;

    function automatic logic [CNT_W-1:0] grid_count(input logic [GSEL_W-1:0] sel);
        if (int'(sel) > SHARED) return CNT_W'(MAX_GRIDS);
        return CNT_W'(DED_GRIDS + int'(sel));
    endfunction

    function automatic seg_word_t data_mask(input logic [CNT_W-1:0] g);
        seg_word_t m;
        for (int i = 0; i < SEG_N; i++)
            m[i] = (i < (SEG_N + DED_GRIDS - int'(g)));
        return m;
    endfunction

endpackage

// File: rtl/vfd_scan_timing.sv
module vfd_scan_timing
    import vfd_scan_pkg::*;
#(
    parameter int SLOT_LEN  = 16,
    parameter int KEY_DWELL = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] grid_cnt,
    input  logic [DIM_W-1:0] dim,
    output scan_pos_t        pos
);

    localparam int KEY_LEN = KEY_SRCS * KEY_DWELL;
    localparam int KSUB_W  = $clog2(KEY_LEN);
    localparam int ON_STEP = SLOT_LEN / 16;

    logic              in_key_q;
    logic [SLOT_W-1:0] slot_q;
    logic [SUB_W-1:0]  sub_q;
    logic [KSUB_W-1:0] ksub_q;

    logic last_sub, last_grid, last_key;
    logic [SUB_W:0] lim;

    assign last_sub  = (sub_q == SUB_W'(SLOT_LEN - 1));
    assign last_grid = ((CNT_W'(slot_q) + CNT_W'(1)) >= grid_cnt);
    assign last_key  = (ksub_q == KSUB_W'(KEY_LEN - 1));
    assign lim       = (SUB_W+1)'((int'(dim) + 1) * ON_STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_key_q <= 1'b0;
            slot_q   <= '0;
            sub_q    <= '0;
            ksub_q   <= '0;
        end else if (!in_key_q) begin
            if (last_sub) begin
                sub_q <= '0;
                if (last_grid) begin
                    in_key_q <= 1'b1;
                    ksub_q   <= '0;
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end else begin
            if (last_key) begin
                in_key_q <= 1'b0;
                slot_q   <= '0;
                sub_q    <= '0;
            end else begin
                ksub_q <= ksub_q + 1'b1;
            end
        end
    end

    always_comb begin
        pos.in_key    = in_key_q;
        pos.slot      = slot_q;
        pos.ksrc      = KSRC_W'(ksub_q / KSUB_W'(KEY_DWELL));
        pos.capture   = in_key_q && ((ksub_q % KSUB_W'(KEY_DWELL)) == KSUB_W'(KEY_DWELL - 1));
        pos.cycle_end = in_key_q && last_key;
        pos.lit       = !in_key_q && ({1'b0, sub_q} < lim);
    end

endmodule

// File: rtl/vfd_disp_store.sv
module vfd_disp_store
    import vfd_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_addr,
    input  seg_word_t         wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output seg_word_t         rd_word
);

    seg_word_t words_q [MAX_GRIDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAX_GRIDS; i++) words_q[i] <= '0;
        end else if (wr_en) begin
            words_q[wr_addr] <= wr_data;
        end
    end

    assign rd_word = words_q[rd_slot];

endmodule

// File: rtl/vfd_seg_latch.sv
module vfd_seg_latch
    import vfd_scan_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_key,
    input  logic                 lit,
    input  logic [SLOT_W-1:0]    slot,
    input  logic [KSRC_W-1:0]    ksrc,
    input  logic                 disp_on,
    input  logic [CNT_W-1:0]     grid_cnt,
    input  seg_word_t            word,
    output seg_word_t            seg_q,
    output logic [DED_GRIDS-1:0] grid_q
);

    seg_word_t            share_bits;
    logic [DED_GRIDS-1:0] ded_bits;
    seg_word_t            src_bits;
    seg_word_t            seg_n;
    logic [DED_GRIDS-1:0] grid_n;

    // Upper grids sit on the top segment lines in reverse order.
    genvar j;
    generate
        for (j = 0; j < SHARED; j++) begin : g_share
            assign share_bits[SEG_N-1-j] = (int'(slot) == DED_GRIDS + j);
        end
        for (j = 0; j < SEG_N - SHARED; j++) begin : g_share_lo
            assign share_bits[j] = 1'b0;
        end
        for (j = 0; j < DED_GRIDS; j++) begin : g_ded
            assign ded_bits[j] = (int'(slot) == j);
        end
        for (j = 0; j < SEG_N; j++) begin : g_src
            if (j < KEY_SRCS) begin : g_on
                assign src_bits[j] = (int'(ksrc) == j);
            end else begin : g_off
                assign src_bits[j] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        seg_n  = '0;
        grid_n = '0;
        if (in_key) begin
            seg_n = src_bits;
        end else if (lit && disp_on) begin
            seg_n  = (word & data_mask(grid_cnt)) | share_bits;
            grid_n = ded_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q  <= '0;
            grid_q <= '0;
        end else begin
            seg_q  <= seg_n;
            grid_q <= grid_n;
        end
    end

endmodule

// File: rtl/vfd_key_store.sv
module vfd_key_store
    import vfd_scan_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                capture,
    input  logic                cycle_end,
    input  logic [KSRC_W-1:0]   ksrc,
    input  key_nib_t            key_ret,
    input  logic                hold,
    input  logic [RD_IDX_W-1:0] rd_idx,
    output logic [7:0]          rd_data,
    output logic [KEY_BITS-1:0] key_flat
);

    key_nib_t stage_q [KEY_SRCS];
    key_nib_t mem_q   [KEY_SRCS];

    genvar s;
    generate
        for (s = 0; s < KEY_SRCS; s++) begin : g_src
            logic hit;
            assign hit = capture && (int'(ksrc) == s);

            always_ff @(posedge clk) begin
                if (rst)      stage_q[s] <= '0;
                else if (hit) stage_q[s] <= key_ret;
            end

            // Commit at cycle end; the source sampled on that same clock
            // is taken straight from the return lines.
            always_ff @(posedge clk) begin
                if (rst)                    mem_q[s] <= '0;
                else if (cycle_end && !hold) mem_q[s] <= hit ? key_ret : stage_q[s];
            end

            assign key_flat[s*KEY_RETS +: KEY_RETS] = mem_q[s];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (int'(rd_idx) < KEY_BYTES) begin
            rd_data <= key_flat[int'(rd_idx)*8 +: 8];
        end else begin
            rd_data <= '0;
        end
    end

endmodule

// File: rtl/vfd_scan_seq.sv
module vfd_scan_seq
    import vfd_scan_pkg::*;
#(
    parameter int SLOT_LEN  = 16,
    parameter int KEY_DWELL = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 disp_on,
    input  logic [GSEL_W-1:0]    grid_sel,
    input  logic [DIM_W-1:0]     dim,
    input  logic                 wr_en,
    input  logic [SLOT_W-1:0]    wr_addr,
    input  logic [SEG_N-1:0]     wr_data,
    input  logic [KEY_RETS-1:0]  key_ret,
    input  logic                 key_rd_hold,
    input  logic [RD_IDX_W-1:0]  key_rd_idx,
    output logic [7:0]           key_rd_data,
    output logic [SEG_N-1:0]     seg_out,
    output logic [DED_GRIDS-1:0] grid_out
);

    logic [CNT_W-1:0]    grid_cnt;
    scan_pos_t           pos;
    seg_word_t           word;
    logic [KEY_BITS-1:0] key_flat;

    assign grid_cnt = grid_count(grid_sel);

    vfd_scan_timing #(
        .SLOT_LEN  (SLOT_LEN),
        .KEY_DWELL (KEY_DWELL)
    ) u_timing (
        .clk      (clk),
        .rst      (rst),
        .grid_cnt (grid_cnt),
        .dim      (dim),
        .pos      (pos)
    );

    vfd_disp_store u_disp (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_slot (pos.slot),
        .rd_word (word)
    );

    vfd_seg_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .in_key   (pos.in_key),
        .lit      (pos.lit),
        .slot     (pos.slot),
        .ksrc     (pos.ksrc),
        .disp_on  (disp_on),
        .grid_cnt (grid_cnt),
        .word     (word),
        .seg_q    (seg_out),
        .grid_q   (grid_out)
    );

    vfd_key_store u_keys (
        .clk       (clk),
        .rst       (rst),
        .capture   (pos.capture),
        .cycle_end (pos.cycle_end),
        .ksrc      (pos.ksrc),
        .key_ret   (key_ret),
        .hold      (key_rd_hold),
        .rd_idx    (key_rd_idx),
        .rd_data   (key_rd_data),
        .key_flat  (key_flat)
    );

endmodule

// File: rtl/vfd_scan_seq_chk.sv
module vfd_scan_seq_chk
    import vfd_scan_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 disp_on,
    input logic                 key_rd_hold,
    input logic [SEG_N-1:0]     seg_out,
    input logic [DED_GRIDS-1:0] grid_out,
    input scan_pos_t            pos,
    input logic [KEY_BITS-1:0]  key_flat
);

    a_r2_one_grid: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grid_out));

    a_r5_dim_blank: assert property (@(posedge clk) disable iff (rst)
        (!pos.in_key && !pos.lit) |=> (grid_out == '0 && seg_out == '0));

    a_r6_off_dark: assert property (@(posedge clk) disable iff (rst)
        (!disp_on && !pos.in_key) |=> (grid_out == '0 && seg_out == '0));

    a_r7_key_single: assert property (@(posedge clk) disable iff (rst)
        pos.in_key |=> (grid_out == '0 && $onehot(seg_out)));

    a_r8_commit_only_at_end: assert property (@(posedge clk) disable iff (rst)
        !pos.cycle_end |=> $stable(key_flat));

    a_r10_hold_freeze: assert property (@(posedge clk) disable iff (rst)
        key_rd_hold |=> $stable(key_flat));

endmodule

bind vfd_scan_seq vfd_scan_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .disp_on     (disp_on),
    .key_rd_hold (key_rd_hold),
    .seg_out     (seg_out),
    .grid_out    (grid_out),
    .pos         (pos),
    .key_flat    (key_flat)
);

// File: tb/vfd_scan_seq_bench.sv
module vfd_scan_seq_bench;

    localparam int SLOT = 16;
    localparam int KLEN = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        disp_on = 1'b1;
    logic [3:0]  grid_sel = 4'd0;
    logic [2:0]  dim = 3'd7;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = 4'd0;
    logic [19:0] wr_data = 20'd0;
    logic [3:0]  key_ret;
    logic        key_rd_hold = 1'b0;
    logic [2:0]  key_rd_idx = 3'd0;
    logic [7:0]  key_rd_data;
    logic [19:0] seg_out;
    logic [7:0]  grid_out;

    logic [3:0]  kmat [12];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit started = 0;

    always #5 clk = ~clk;

    vfd_scan_seq u_vfd_scan_seq (
        .clk(clk), .rst(rst), .disp_on(disp_on), .grid_sel(grid_sel), .dim(dim),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .key_ret(key_ret),
        .key_rd_hold(key_rd_hold), .key_rd_idx(key_rd_idx), .key_rd_data(key_rd_data),
        .seg_out(seg_out), .grid_out(grid_out)
    );

    // Key matrix: a driven source pulls its returns high.
    always_comb begin
        key_ret = 4'd0;
        for (int s = 0; s < 12; s++)
            if (seg_out[s]) key_ret = key_ret | kmat[s];
    end

    // Behavioural reference model.
    bit          m_inkey;
    int          m_slot, m_sub, m_ksub;
    logic [19:0] m_dmem [16];
    logic [3:0]  m_stage [12];
    logic [3:0]  m_kmem [12];
    logic [19:0] exp_seg;
    logic [7:0]  exp_grid, exp_rd;
    string       exp_tag;

    always @(posedge clk) begin
        int g, lim, src, idx;
        started = 1;
        cyc++;
        if (rst) begin
            m_inkey = 0; m_slot = 0; m_sub = 0; m_ksub = 0;
            for (int i = 0; i < 16; i++) m_dmem[i] = '0;
            for (int i = 0; i < 12; i++) begin m_stage[i] = '0; m_kmem[i] = '0; end
            exp_seg = '0; exp_grid = '0; exp_rd = '0; exp_tag = "R1 reset";
        end else begin
            g   = (grid_sel > 8) ? 16 : 8 + int'(grid_sel);
            lim = (int'(dim) + 1) * SLOT / 16;
            idx = int'(key_rd_idx);
            exp_rd = (idx < 6) ? {m_kmem[2*idx+1], m_kmem[2*idx]} : 8'd0;
            exp_seg = '0; exp_grid = '0;
            if (!m_inkey) begin
                if (!disp_on)          exp_tag = "R6 display off";
                else if (m_sub >= lim) exp_tag = "R5 dim window";
                else begin
                    exp_tag = (m_slot >= 8) ? "R3/R4/R11 shared-grid slot" : "R2/R4/R11 grid slot";
                    for (int i = 0; i < 20; i++)
                        if (i < 28 - g) exp_seg[i] = m_dmem[m_slot][i];
                    if (m_slot < 8) exp_grid[m_slot] = 1'b1;
                    else            exp_seg[27 - m_slot] = 1'b1;
                end
                if (m_sub == SLOT - 1) begin
                    m_sub = 0;
                    if (m_slot >= g - 1) begin m_inkey = 1; m_ksub = 0; end
                    else m_slot++;
                end else m_sub++;
            end else begin
                exp_tag = "R7 key scan";
                src = m_ksub / 2;
                exp_seg[src] = 1'b1;
                if (m_ksub % 2 == 1) m_stage[src] = key_ret;
                if (m_ksub == KLEN - 1) begin
                    if (!key_rd_hold)
                        for (int i = 0; i < 12; i++) m_kmem[i] = m_stage[i];
                    m_inkey = 0; m_slot = 0; m_sub = 0;
                end else m_ksub++;
            end
            if (wr_en) m_dmem[wr_addr] = wr_data;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (seg_out !== exp_seg) begin
                errors++;
                $display("FAIL %s seg_out: actual %h expected %h (cycle %0d)", exp_tag, seg_out, exp_seg, cyc);
            end
            checks++;
            if (grid_out !== exp_grid) begin
                errors++;
                $display("FAIL %s grid_out: actual %h expected %h (cycle %0d)", exp_tag, grid_out, exp_grid, cyc);
            end
            checks++;
            if (key_rd_data !== exp_rd) begin
                errors++;
                $display("FAIL R8/R9/R10 key_rd_data: actual %h expected %h (cycle %0d)", key_rd_data, exp_rd, cyc);
            end
        end
    end

    // Readout index sweeps all eight values, including the empty ones.
    always @(negedge clk) key_rd_idx <= key_rd_idx + 3'd1;

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_word(input int a, input logic [19:0] d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_keys(input int seed);
        for (int s = 0; s < 12; s++) kmat[s] = 4'((s * 5 + seed * 3 + 1) ^ seed);
    endtask

    task automatic check_reset;
        checks++;
        if (seg_out !== '0 || grid_out !== '0 || key_rd_data !== '0) begin
            errors++;
            $display("FAIL R1 reset outputs: actual %h/%h/%h expected 0", seg_out, grid_out, key_rd_data);
        end
    endtask

    initial begin
        for (int s = 0; s < 12; s++) kmat[s] = 4'd0;
        run(4);
        check_reset();
        @(negedge clk); rst = 1'b0;
        // R11: fill display store while scanning
        for (int a = 0; a < 16; a++) write_word(a, 20'((a * 20'h1F3A5) ^ (20'hA5A5A << a)));
        set_keys(1);
        run(300);                       // R2 eight grids, full brightness
        grid_sel = 4'd8; set_keys(2);   // R3 sixteen grids
        run(600);
        grid_sel = 4'd3;                // R3 eleven grids
        write_word(9, 20'hFFFFF);
        run(450);
        grid_sel = 4'd15;               // saturates at sixteen
        dim = 3'd0; set_keys(3);        // R5 shortest window
        run(600);
        dim = 3'd3; grid_sel = 4'd0;
        run(320);
        disp_on = 1'b0; set_keys(4);    // R6 with key scan continuing (R7)
        run(320);
        disp_on = 1'b1; dim = 3'd7;
        key_rd_hold = 1'b1; set_keys(5); // R10 hold across a cycle end
        run(330);
        key_rd_hold = 1'b0;
        run(330);                        // R8 commit after release
        rst = 1'b1; run(2);
        check_reset();
        rst = 1'b0; run(40);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule